// File: doc/BRIEF.md
# Multi-core hardware mutex bank

This block is a bank of hardware locks that several cores share. Each lock stores whether it is held and, if so, which core holds it. Every core has its own request port, made of a valid strobe, a write flag, a lock index and a one-bit write value. A core writes 1 to try to take a lock and writes 0 to give it back. A read tells the core whether it is the current holder. When the core wrote 1, that read shows whether the attempt succeeded.

The block is meant to sit behind the device-register decode of each core, in the high part of the address map (0xFC00 to 0xFFFF). The decoder passes only the lock index on to the bank. All locks are free after reset. When several cores try to take the same free lock in one cycle, the lowest-numbered core gets it. A write of 0 from any core other than the holder does nothing. Read data is registered and comes back one cycle after the request. It reflects the lock state from before any writes made in that same cycle.

Top module: `hwmtx_bank`

## Requirements
- R1: After reset every lock is free, so a read of any lock by any core returns 0.
- R2: A write of 1 (valid=1, we=1, wdata=1) to a free lock by a single core makes that core the holder.
- R3: A write of 1 to a lock that is already held leaves the holder unchanged. This applies whether the writer is the holder or another core.
- R4: When several cores write 1 to the same free lock in the same cycle, the core with the lowest port number becomes the holder.
- R5: A write of 0 (valid=1, we=1, wdata=0) from the holding core frees the lock.
- R6: A write of 0 from a core that does not hold the lock, or to a free lock, has no effect.
- R7: A read (valid=1, we=0) returns 1 on that core's rd_data_o bit in the next cycle if the reading core held the lock, and 0 otherwise. The value is taken from the state before any write made in the same cycle.
- R8: A core's rd_data_o bit is 0 in the cycle after that core made no read request.
- R9: Acquire attempts are judged against the state before the clock edge. If the holder releases a lock while another core writes 1 to it in the same cycle, the lock ends up free.
- R10: Requests to different locks in the same cycle are handled independently of each other.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_valid_i | input | N_CORES | Per-core request strobe |
| req_we_i | input | N_CORES | Per-core write flag (1 = write, 0 = read) |
| req_wdata_i | input | N_CORES | Per-core write value (1 = acquire, 0 = release) |
| req_idx_i | input | N_CORES*IDXW | Per-core lock index; core c uses bits [c*IDXW +: IDXW] |
| rd_data_o | output | N_CORES | Per-core ownership read result, one cycle after the read |

## Verification
The assertions assume that reset is applied before the first request. They also assume that each lock index is below N_MUTEX; an index outside that range matches no lock, so a read of it returns 0. The stimulus drives only in-range indices and changes inputs only on the falling clock edge. The directed part sweeps every lock with every set of competing cores. It then issues releases from each core that does not hold the lock, re-acquire attempts, and a release from the holder in the same cycle as an acquire by another core. A seeded pseudo-random phase mixes reads, acquires and releases across all ports. A bench model computes the expected result of each read from the requirements.

// File: rtl/hwmtx_pkg.sv
package hwmtx_pkg;
  typedef enum logic [1:0] {
    OP_IDLE,
    OP_READ,
    OP_ACQ,
    OP_REL
  } mtx_op_e;

  function automatic mtx_op_e op_decode(logic v, logic we, logic wd);
    if (!v) return OP_IDLE;
    if (!we) return OP_READ;
    return wd ? OP_ACQ : OP_REL;
  endfunction
endpackage

// File: rtl/hwmtx_req_dec.sv
module hwmtx_req_dec
  import hwmtx_pkg::*;
#(
  parameter int N_MUTEX = 8,
  parameter int IDXW    = 3
) (
  input  logic               valid_i,
  input  logic               we_i,
  input  logic               wdata_i,
  input  logic [IDXW-1:0]    idx_i,
  output logic [N_MUTEX-1:0] acq_o,
  output logic [N_MUTEX-1:0] rel_o,
  output logic               rd_o
);
  mtx_op_e op;

  assign op   = op_decode(valid_i, we_i, wdata_i);
  assign rd_o = (op == OP_READ);

  always_comb begin
    for (int m = 0; m < N_MUTEX; m++) begin
      acq_o[m] = (idx_i == IDXW'(m)) && (op == OP_ACQ);
      rel_o[m] = (idx_i == IDXW'(m)) && (op == OP_REL);
    end
  end
endmodule

// File: rtl/hwmtx_pick.sv
module hwmtx_pick #(
  parameter int WIDTH = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] req_i,
  output logic [WIDTH-1:0] gnt_o
);
  // fixed priority, bit 0 highest
  always_comb begin
    logic found;
    found = 1'b0;
    gnt_o = '0;
    for (int i = 0; i < WIDTH; i++) begin
      if (req_i[i] && !found) begin
        gnt_o[i] = 1'b1;
        found    = 1'b1;
      end
    end
  end

  a_r4_onehot: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(gnt_o) && ((gnt_o & ~req_i) == '0));
  a_r4_lowest: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i != '0) |-> (gnt_o == (req_i & (~req_i + WIDTH'(1)))));
endmodule

// File: rtl/hwmtx_slot.sv
module hwmtx_slot #(
  parameter int N_CORES = 4,
  parameter int CIDW    = 2
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [N_CORES-1:0] acq_i,
  input  logic [N_CORES-1:0] rel_i,
  output logic               held_o,
  output logic [CIDW-1:0]    owner_o
);
  logic               held_q, held_d;
  logic [CIDW-1:0]    owner_q, owner_d;
  logic [N_CORES-1:0] gnt;

  hwmtx_pick #(.WIDTH(N_CORES)) u_pick (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .req_i (acq_i),
    .gnt_o (gnt)
  );

  always_comb begin
    held_d  = held_q;
    owner_d = owner_q;
    if (held_q) begin
      if (rel_i[owner_q]) held_d = 1'b0;
    end else if (gnt != '0) begin
      held_d = 1'b1;
      for (int i = 0; i < N_CORES; i++) begin
        if (gnt[i]) owner_d = CIDW'(i);
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      held_q  <= 1'b0;
      owner_q <= '0;
    end else begin
      held_q  <= held_d;
      owner_q <= owner_d;
    end
  end

  assign held_o  = held_q;
  assign owner_o = owner_q;

  a_r3_keep_owner: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (held_q && !rel_i[owner_q]) |=> (held_q && (owner_q == $past(owner_q))));
  a_r5_release: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (held_q && rel_i[owner_q]) |=> !held_q);
  a_r2_take: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!held_q && (acq_i != '0)) |=> held_q);
  a_r6_stay_free: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!held_q && (acq_i == '0)) |=> !held_q);
endmodule

// File: rtl/hwmtx_bank.sv
module hwmtx_bank
  import hwmtx_pkg::*;
#(
  parameter int N_CORES = 4,
  parameter int N_MUTEX = 8,
  localparam int IDXW   = (N_MUTEX > 1) ? $clog2(N_MUTEX) : 1,
  localparam int CIDW   = (N_CORES > 1) ? $clog2(N_CORES) : 1
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic [N_CORES-1:0]      req_valid_i,
  input  logic [N_CORES-1:0]      req_we_i,
  input  logic [N_CORES-1:0]      req_wdata_i,
  input  logic [N_CORES*IDXW-1:0] req_idx_i,
  output logic [N_CORES-1:0]      rd_data_o
);
  logic [N_MUTEX-1:0] acq_m [N_CORES];
  logic [N_MUTEX-1:0] rel_m [N_CORES];
  logic [N_CORES-1:0] acq_t [N_MUTEX];
  logic [N_CORES-1:0] rel_t [N_MUTEX];
  logic [N_CORES-1:0] rd_req;
  logic               held  [N_MUTEX];
  logic [CIDW-1:0]    owner [N_MUTEX];

  for (genvar c = 0; c < N_CORES; c++) begin : g_dec
    hwmtx_req_dec #(.N_MUTEX(N_MUTEX), .IDXW(IDXW)) u_dec (
      .valid_i(req_valid_i[c]),
      .we_i   (req_we_i[c]),
      .wdata_i(req_wdata_i[c]),
      .idx_i  (req_idx_i[c*IDXW +: IDXW]),
      .acq_o  (acq_m[c]),
      .rel_o  (rel_m[c]),
      .rd_o   (rd_req[c])
    );
  end

  always_comb begin
    for (int m = 0; m < N_MUTEX; m++) begin
      for (int c = 0; c < N_CORES; c++) begin
        acq_t[m][c] = acq_m[c][m];
        rel_t[m][c] = rel_m[c][m];
      end
    end
  end

  for (genvar m = 0; m < N_MUTEX; m++) begin : g_slot
    hwmtx_slot #(.N_CORES(N_CORES), .CIDW(CIDW)) u_slot (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .acq_i  (acq_t[m]),
      .rel_i  (rel_t[m]),
      .held_o (held[m]),
      .owner_o(owner[m])
    );
  end

  // read result uses pre-edge state, registered once
  for (genvar c = 0; c < N_CORES; c++) begin : g_rd
    logic own_hit;
    logic rd_q;

    always_comb begin
      own_hit = 1'b0;
      for (int m = 0; m < N_MUTEX; m++) begin
        if (req_idx_i[c*IDXW +: IDXW] == IDXW'(m))
          own_hit = held[m] && (owner[m] == CIDW'(c));
      end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) rd_q <= 1'b0;
      else         rd_q <= rd_req[c] && own_hit;
    end

    assign rd_data_o[c] = rd_q;

    a_r8_idle_low: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !rd_req[c] |=> !rd_data_o[c]);
  end
endmodule

// File: tb/sim_hwmtx_bank.sv
module sim_hwmtx_bank;
  localparam int CLK_PERIOD = 10;
  localparam int NC = 4;
  localparam int NM = 8;
  localparam int IW = 3;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [NC-1:0] v, we, wd;
  logic [NC*IW-1:0] ix;
  logic [NC-1:0] rd;

  int checks = 0;
  int errors = 0;
  bit held_m [NM];
  int own_m  [NM];

  always #(CLK_PERIOD/2) clk = ~clk;

  hwmtx_bank #(.N_CORES(NC), .N_MUTEX(NM)) u0 (
    .clk_i      (clk),
    .rst_ni     (rst_n),
    .req_valid_i(v),
    .req_we_i   (we),
    .req_wdata_i(wd),
    .req_idx_i  (ix),
    .rd_data_o  (rd)
  );

  task automatic clr();
    v = '0; we = '0; wd = '0; ix = '0;
  endtask

  task automatic put(int c, bit pv, bit pwe, bit pwd, int idx);
    v[c] = pv; we[c] = pwe; wd[c] = pwd; ix[c*IW +: IW] = IW'(idx);
  endtask

  // apply current stimulus for one cycle, check reads against the model
  task automatic step(string tag);
    bit exp [NC];
    bit nh [NM];
    int no [NM];
    for (int c = 0; c < NC; c++) begin
      int i = int'(ix[c*IW +: IW]);
      exp[c] = v[c] && !we[c] && held_m[i] && (own_m[i] == c);
    end
    for (int m = 0; m < NM; m++) begin
      nh[m] = held_m[m];
      no[m] = own_m[m];
      if (held_m[m]) begin
        int o = own_m[m];
        if (v[o] && we[o] && !wd[o] && int'(ix[o*IW +: IW]) == m) nh[m] = 1'b0;
      end else begin
        for (int c = NC-1; c >= 0; c--)
          if (v[c] && we[c] && wd[c] && int'(ix[c*IW +: IW]) == m) begin
            nh[m] = 1'b1;
            no[m] = c;
          end
      end
    end
    @(posedge clk);
    #1;
    for (int c = 0; c < NC; c++) begin
      checks++;
      if (rd[c] !== exp[c]) begin
        errors++;
        $display("FAIL %s core %0d rd_data=%0b expected=%0b", tag, c, rd[c], exp[c]);
      end
    end
    for (int m = 0; m < NM; m++) begin
      held_m[m] = nh[m];
      own_m[m]  = no[m];
    end
    @(negedge clk);
    clr();
  endtask

  task automatic read_all(int m, string tag);
    for (int c = 0; c < NC; c++) put(c, 1'b1, 1'b0, 1'b0, m);
    step(tag);
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    errors++;
    $display("FAIL watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    int lo;
    int other;
    bit [31:0] s;
    clr();
    for (int m = 0; m < NM; m++) begin
      held_m[m] = 1'b0;
      own_m[m]  = 0;
    end
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1: all free after reset
    for (int m = 0; m < NM; m++) read_all(m, "R1");

    for (int m = 0; m < NM; m++) begin
      for (int mask = 1; mask < (1 << NC); mask++) begin
        // R4/R2: contention on a free lock; R7: a non-contender reads it
        for (int c = 0; c < NC; c++)
          if (mask[c]) put(c, 1'b1, 1'b1, 1'b1, m);
          else         put(c, 1'b1, 1'b0, 1'b0, m);
        step("R4");
        lo = 0;
        while (!mask[lo]) lo++;
        read_all(m, "R7");
        // R6: release by each non-holder, then readback
        for (int c = 0; c < NC; c++)
          if (c != lo) begin
            put(c, 1'b1, 1'b1, 1'b0, m);
            step("R6");
            read_all(m, "R6");
          end
        // R3: every core tries to acquire the held lock
        for (int c = 0; c < NC; c++) put(c, 1'b1, 1'b1, 1'b1, m);
        step("R3");
        read_all(m, "R3");
        // R9: holder releases while another core acquires
        other = (lo + 1) % NC;
        put(lo, 1'b1, 1'b1, 1'b0, m);
        put(other, 1'b1, 1'b1, 1'b1, m);
        step("R9");
        read_all(m, "R9");
        // R5: lock is free; take by 'other', release by holder
        put(other, 1'b1, 1'b1, 1'b1, m);
        step("R2");
        put(other, 1'b1, 1'b1, 0, m);
        step("R5");
        read_all(m, "R5");
        // R6: release of a free lock
        put(lo, 1'b1, 1'b1, 1'b0, m);
        step("R6");
        // R8: idle cycle keeps all read data low
        step("R8");
      end
    end

    // R10: mixed traffic across locks and ports
    s = 32'h1234_5678;
    for (int n = 0; n < 3000; n++) begin
      for (int c = 0; c < NC; c++) begin
        s ^= s << 13; s ^= s >> 17; s ^= s << 5;
        put(c, s[0] | s[1], s[2], s[3], int'(s[6:4]));
      end
      step("R10");
    end
    for (int m = 0; m < NM; m++) read_all(m, "R10");

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule